// File: doc/BRIEF.md
# Synchronous memory bus cycle controller

This block is a bus master that sits between a processor core and a parallel memory bus. The core asks for one read or one write at a time. The block turns that request into a cycle on the bus with a fixed shape: a setup clock, one or more middle clocks and a final clock. In the setup clock the address is driven and the strobe for the chosen direction goes high. The middle clock repeats as a wait state for as long as the memory holds its ready input low. In the final clock the strobe is released and the core sees a one-clock completion pulse.

For a read, the data bus is sampled in the middle clock where ready is found high. The value appears on the core's read-data port together with the completion pulse, and it stays there until another read completes without error. For a write, the stored write data is driven onto the bus. The output enable is raised from the middle phase through the final clock. A memory that stays not-ready for more than a parameterised number of wait clocks causes the cycle to be aborted. The abort is reported with an error flag that comes with the completion pulse.

Top module: `membus_master`

## Requirements
- R1: After reset, busRd, busWr, busDoutEn, rspDone and rspErr are 0 and rspRdata is 0.
- R2: A read with busReady high at the first middle-clock sample takes exactly three clocks. busRd is high in clocks 1 and 2, and busRd is 0 with rspDone 1 in clock 3. Clock 1 is the clock after the one in which reqValid was sampled high in idle.
- R3: A write has the same three-clock shape using busWr. busDoutEn is 1 from clock 2 through the completion clock and 0 in clock 1 and in idle. busDout equals the request's write data whenever busDoutEn is 1.
- R4: Each middle-phase clock in which busReady is sampled low adds exactly one clock to the cycle. With k low samples (k ≤ MAX_WAIT) the cycle lasts k+3 clocks, and the strobe stays high until the completion clock.
- R5: For a read, rspRdata shows busDin as sampled in the middle clock where busReady was high. It is valid in the completion clock and is held afterwards. Writes and aborted reads leave rspRdata unchanged.
- R6: busAddr equals the request address in every clock where busRd or busWr is high.
- R7: The controller tolerates up to MAX_WAIT low ready samples (default 8). A further low sample aborts the cycle: the next clock is the completion clock, with the strobe at 0, rspDone 1 and rspErr 1. The cycle then lasts MAX_WAIT+3 clocks.
- R8: rspDone is high for exactly one clock per cycle. rspErr is 1 only together with rspDone, and only when the cycle was aborted.
- R9: A request is accepted only in idle. A reqValid raised during a cycle does not change busAddr and does not start a further cycle once the current one has ended.
- R10: busDoutEn is never 1 in a read cycle, and busRd and busWr are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core asks for a cycle (accepted in idle only) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Address of the request |
| reqWdata | input | DATA_W | Data for a write |
| rspRdata | output | DATA_W | Last successfully read data |
| rspDone | output | 1 | One-clock pulse at the end of a cycle |
| rspErr | output | 1 | Cycle aborted by wait timeout (with rspDone) |
| busAddr | output | ADDR_W | Memory address bus |
| busDout | output | DATA_W | Data driven toward memory |
| busDin | input | DATA_W | Data returned by memory |
| busDoutEn | output | 1 | Output enable for busDout |
| busRd | output | 1 | Read strobe, active high |
| busWr | output | 1 | Write strobe, active high |
| busReady | input | 1 | Memory ready, sampled in middle phase |

## Verification
The assertions assume that busReady and busDin are settled at each rising edge. They give busReady meaning only in the middle phase, so a ready input that toggles in setup or in the final clock can never violate them. The bench drives every input just after a falling edge. It raises busReady only in the middle-phase clock picked by each vector's wait count, and it drops reqValid in the first clock of a cycle. Only the intrusion test raises reqValid during a cycle, and it clears reqValid again before the controller returns to idle.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_MID    = 2'd2,
    ST_FINISH = 2'd3
  } busState_t;

  typedef struct packed {
    logic load;     // latch request address and write data
    logic capture;  // latch the data bus into the read register
  } dpCtrl_t;

endpackage

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int MAX_WAIT = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    busReady,
  output dpCtrl_t dpCtrl,
  output logic    busRd,
  output logic    busWr,
  output logic    busDoutEn,
  output logic    rspDone,
  output logic    rspErr
);

  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  busState_t  state, stateNext;
  logic       isWrite;
  logic       errQ;
  logic [CNT_W-1:0] waitCnt;

  logic waitLimit;
  assign waitLimit = (waitCnt == CNT_W'(MAX_WAIT));

  always_comb begin
    stateNext      = state;
    dpCtrl.load    = 1'b0;
    dpCtrl.capture = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext   = ST_SETUP;
          dpCtrl.load = 1'b1;
        end
      end
      ST_SETUP: stateNext = ST_MID;
      ST_MID: begin
        if (busReady) begin
          stateNext      = ST_FINISH;
          dpCtrl.capture = !isWrite;
        end else if (waitLimit) begin
          stateNext = ST_FINISH;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
      errQ    <= 1'b0;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && reqValid) begin
        isWrite <= reqWrite;
        errQ    <= 1'b0;
        waitCnt <= '0;
      end else if (state == ST_MID && !busReady) begin
        if (waitLimit) errQ <= 1'b1;
        else           waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  logic strobeOn;
  assign strobeOn  = (state == ST_SETUP) || (state == ST_MID);
  assign busRd     = strobeOn && !isWrite;
  assign busWr     = strobeOn && isWrite;
  assign busDoutEn = isWrite && ((state == ST_MID) || (state == ST_FINISH));
  assign rspDone   = (state == ST_FINISH);
  assign rspErr    = (state == ST_FINISH) && errQ;

  // R8: completion is a single-clock pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R8: error flag only alongside completion
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspDone);

  // R10: strobes exclusive, no drive during a read
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));
  a_r10_no_drive_read: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> !busDoutEn);

  // R4: a low ready below the limit keeps the strobe up for another clock
  a_r4_wait_stretch: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MID && !busReady && !waitLimit) |=> (busRd || busWr));

  // R7: a low ready at the limit ends the cycle with an error
  a_r7_timeout_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MID && !busReady && waitLimit) |=> (rspDone && rspErr && !busRd && !busWr));

endmodule

// File: rtl/membus_dp.sv
module membus_dp
  import membus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (dpCtrl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdataQ <= '0;
    else if (dpCtrl.capture) rdataQ <= busDin;
  end

  assign busAddr  = addrQ;
  assign busDout  = wdataQ;
  assign rspRdata = rdataQ;

  // R5: read register changes only on a capture strobe
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.capture |=> $stable(rdataQ));

endmodule

// File: rtl/membus_master.sv
module membus_master
  import membus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic              rspErr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  input  logic [DATA_W-1:0] busDin,
  output logic              busDoutEn,
  output logic              busRd,
  output logic              busWr,
  input  logic              busReady
);

  dpCtrl_t dpCtrl;

  membus_ctrl #(.MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busReady(busReady), .dpCtrl(dpCtrl), .busRd(busRd), .busWr(busWr),
    .busDoutEn(busDoutEn), .rspDone(rspDone), .rspErr(rspErr)
  );

  membus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busDin(busDin), .busAddr(busAddr),
    .busDout(busDout), .rspRdata(rspRdata)
  );

  // R6: address held steady while a strobe stays up
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd || busWr) && $past(busRd || busWr)) |-> $stable(busAddr));

  // R3: write data steady while it is driven
  a_r3_dout_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busDoutEn && $past(busDoutEn)) |-> $stable(busDout));

endmodule

// File: tb/membus_master_tb.sv
module membus_master_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MAXW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] rspRdata;
  logic rspDone, rspErr;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDout;
  logic [DW-1:0] busDin = '0;
  logic busDoutEn, busRd, busWr;
  logic busReady = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] lastRead = '0;

  always #5 clk = ~clk;

  membus_master #(.ADDR_W(AW), .DATA_W(DW), .MAX_WAIT(MAXW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .rspDone(rspDone), .rspErr(rspErr), .busAddr(busAddr), .busDout(busDout),
    .busDin(busDin), .busDoutEn(busDoutEn), .busRd(busRd), .busWr(busWr),
    .busReady(busReady)
  );

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [7:0]    waits;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 16'h1234, 32'hA5A5_0001, 8'd0},
    '{1'b1, 16'h0F00, 32'hDEAD_BEEF, 8'd0},
    '{1'b0, 16'h0040, 32'h1357_2468, 8'd2},
    '{1'b1, 16'h0044, 32'hCAFE_0001, 8'd5},
    '{1'b0, 16'h7FFC, 32'hFFFF_0000, 8'd8},
    '{1'b1, 16'h0000, 32'h0000_0000, 8'd1},
    '{1'b0, 16'h8001, 32'h0F0F_F0F0, 8'd1}
  };

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic wr, input logic [AW-1:0] addr, input logic [DW-1:0] data,
                       input int waits, input logic intrude);
    int expDone, doneAt, lenSeen;
    logic abort, strobeOk, doneOk, errOk, addrOk, enOk, doutOk;
    logic [DW-1:0] rdAtDone, rdAfter, expRd;
    abort   = (waits > MAXW);
    expDone = abort ? MAXW + 3 : waits + 3;
    strobeOk = 1; doneOk = 1; errOk = 1; addrOk = 1; enOk = 1; doutOk = 1;
    doneAt = 0; lenSeen = 0; rdAtDone = '0; rdAfter = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data;
    busDin = wr ? 32'h5555_AAAA : data;
    busReady = 1'b0;
    for (int cyc = 1; cyc <= expDone + 1; cyc++) begin
      @(negedge clk);
      if (cyc == 1) reqValid = 1'b0;
      if (intrude && cyc == 2) begin reqValid = 1'b1; reqAddr = ~addr; reqWrite = 1'b1; end
      if (intrude && cyc == 3) reqValid = 1'b0;
      if (cyc < expDone) strobeOk &= (busRd == !wr) && (busWr == wr);
      else               strobeOk &= !busRd && !busWr;
      if (busRd || busWr) begin addrOk &= (busAddr == addr); lenSeen++; end
      doneOk &= (rspDone == (cyc == expDone));
      if (rspDone && doneAt == 0) doneAt = cyc;
      errOk &= (rspErr == (cyc == expDone && abort));
      enOk &= (busDoutEn == (wr && cyc >= 2 && cyc <= expDone));
      if (busDoutEn) doutOk &= (busDout == data);
      if (cyc == expDone) rdAtDone = rspRdata;
      if (cyc == expDone + 1) rdAfter = rspRdata;
      busReady = (cyc >= waits + 2);
    end
    busReady = 1'b0;
    expRd = (!wr && !abort) ? data : lastRead;
    lastRead = expRd;
    check(strobeOk, wr ? "R3 write strobe shape" : "R2 read strobe shape", 64'(lenSeen), 64'(expDone - 1));
    check(doneOk, abort ? "R7 abort length / R8 pulse" : "R4 cycle length / R8 pulse", 64'(doneAt), 64'(expDone));
    check(errOk, "R8 error flag", 64'(abort), 64'(abort));
    check(addrOk, "R6 address stable", 64'(busAddr), 64'(addr));
    check(enOk, "R10 R3 output enable window", 64'(busDoutEn), 64'(wr));
    check(doutOk, "R3 write data on bus", 64'(busDout), 64'(data));
    check(rdAtDone == expRd, "R5 read data at done", 64'(rdAtDone), 64'(expRd));
    check(rdAfter == expRd, "R5 read data held", 64'(rdAfter), 64'(expRd));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic quiet;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(!busRd && !busWr && !busDoutEn && !rspDone && !rspErr, "R1 reset outputs",
          64'({busRd, busWr, busDoutEn, rspDone, rspErr}), 64'd0);
    check(rspRdata == '0, "R1 reset read data", 64'(rspRdata), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++)
      runOp(VECS[i].wr, VECS[i].addr, VECS[i].data, int'(VECS[i].waits), 1'b0);

    // R7: one wait past the limit aborts a read; read data kept
    runOp(1'b0, 16'h2222, 32'h1111_2222, MAXW + 1, 1'b0);
    // R7: abort of a write
    runOp(1'b1, 16'h3333, 32'h3333_4444, MAXW + 5, 1'b0);
    // R9: request during a cycle is ignored
    runOp(1'b0, 16'h4444, 32'h7777_8888, 0, 1'b1);
    quiet = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      quiet &= !busRd && !busWr && !rspDone;
    end
    check(quiet, "R9 no extra cycle from mid-cycle request", 64'(quiet), 64'd1);
    // R9: next request accepted from idle right away
    runOp(1'b1, 16'h5555, 32'h0102_0304, 0, 1'b0);
    // R5: write after read keeps read data
    check(rspRdata == 32'h7777_8888, "R5 read data after write", 64'(rspRdata), 64'h7777_8888);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule